// File: doc/BRIEF.md
# Mixed-Width Synchronous FIFO

This block is a single-clock first-in first-out buffer built over one fixed-size store of up to 4,608 bits. The write port and the read port each take a width chosen at build time from 1, 2, 4, 9 or 18 bits. The wider of the two widths must be a whole multiple of the narrower one. When the widths differ, a wide word written on one side comes out as a run of narrower words on the other side, least significant bits first. Several narrow writes can also be gathered into one wide read.

Internal counters produce the write and read addresses, so the surrounding logic only drives enables and data. Fill level is counted in bits. This lets the exact flags work for any pairing of widths. Empty means fewer bits are stored than one read word holds. Full means less space is free than one write word needs. Two more flags, almost-empty and almost-full, compare the bit count with thresholds supplied on input ports.

The usable capacity is 4,608 bits when either width is 9 or 18. Otherwise it is 4,096 bits, which gives the 1k×4, 2k×2 and 4k×1 organisations.

Top module: `mixw_fifo`

## Requirements
- R1: While and after synchronous reset, the block is empty: empty=1, full=0, rd_data=0, and almost_empty=1.
- R2: An accepted read puts its data on rd_data at the next clock edge, which is one cycle of latency. rd_data keeps that value until the next accepted read. With the default widths (write 4, read 1), write bit 0 is read first and write bit 3 is read last.
- R3: Data leaves the FIFO in the order it was written, including after the internal addresses wrap around the end of the store.
- R4: empty is 1 exactly when the stored bit count is less than the read width.
- R5: full is 1 exactly when the free bit count is less than the write width. With the default widths this happens after 1,024 writes into an empty FIFO (4,096 bits).
- R6: A write while full is ignored and stores nothing. Draining afterwards returns only the data written before the FIFO filled, and then empty is 1.
- R7: A read while empty is ignored. rd_data and empty are unchanged, and the next written data is the next data read.
- R8: almost_full is 1 exactly when the stored bit count is greater than or equal to af_level.
- R9: almost_empty is 1 exactly when the stored bit count is less than or equal to ae_level.
- R10: When a write and a read are both accepted in one cycle, the bit count changes by the write width minus the read width, and both transfers take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_W | Write word; bit 0 is stored first |
| rd_en | input | 1 | Read request |
| rd_data | output | RD_W | Registered read word |
| ae_level | input | CW | Almost-empty threshold, in bits |
| af_level | input | CW | Almost-full threshold, in bits |
| empty | output | 1 | Fewer bits stored than one read word |
| full | output | 1 | Less space free than one write word |
| almost_empty | output | 1 | Bit count at or below ae_level |
| almost_full | output | 1 | Bit count at or above af_level |

## Verification
The flag assertions only say that a flag can newly rise after a matching request. They therefore assume that the thresholds stay constant across the cycle being checked, and they exempt any cycle in which a threshold changes. The stimulus changes ae_level and af_level only while the FIFO is idle, never in the same cycle as a transfer. It also keeps reset asserted for several cycles, so the checker's first look at past values falls on reset values.

// File: rtl/mixw_fifo_pkg.sv
package mixw_fifo_pkg;

    localparam int unsigned STORE_MAX_BITS = 4608;
    localparam int unsigned STORE_POW2_BITS = 4096;

    // Usable capacity for a pair of port widths
    function automatic int unsigned span_bits(input int unsigned a, input int unsigned b);
        return ((a % 9 == 0) || (b % 9 == 0)) ? STORE_MAX_BITS : STORE_POW2_BITS;
    endfunction

    typedef struct packed {
        logic empty;
        logic full;
        logic almost_empty;
        logic almost_full;
    } flag_t;

endpackage

// File: rtl/mixw_fifo_ptr.sv
module mixw_fifo_ptr #(
    parameter int unsigned STEP = 1,
    parameter int unsigned CAP  = 4096,
    parameter int unsigned PW   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW:0] STEP_V = STEP[PW:0];
    localparam logic [PW:0] CAP_V  = CAP[PW:0];

    logic [PW:0] sum;

    always_comb begin
        sum = {1'b0, ptr} + STEP_V;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (sum >= CAP_V) ? '0 : sum[PW-1:0];
        end
    end
endmodule

// File: rtl/mixw_fifo_store.sv
module mixw_fifo_store #(
    parameter int unsigned CAP = 4096,
    parameter int unsigned WW  = 4,
    parameter int unsigned RW  = 1,
    parameter int unsigned PW  = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] wptr,
    input  logic [WW-1:0] wdata,
    input  logic          re,
    input  logic [PW-1:0] rptr,
    output logic [RW-1:0] rdata
);
    logic [CAP-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (we) begin
            bits_q[wptr +: WW] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= bits_q[rptr +: RW];
        end
    end
endmodule

// File: rtl/mixw_fifo_level.sv
module mixw_fifo_level
    import mixw_fifo_pkg::*;
#(
    parameter int unsigned CAP = 4096,
    parameter int unsigned WW  = 4,
    parameter int unsigned RW  = 1,
    parameter int unsigned CW  = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [CW-1:0] ae_lvl,
    input  logic [CW-1:0] af_lvl,
    output logic          wr_ok,
    output logic          rd_ok,
    output flag_t         flags
);
    localparam logic [CW-1:0] CAP_V = CAP[CW-1:0];
    localparam logic [CW-1:0] WW_V  = WW[CW-1:0];
    localparam logic [CW-1:0] RW_V  = RW[CW-1:0];

    logic [CW-1:0] fill_q;

    always_comb begin
        flags.empty        = fill_q < RW_V;
        flags.full         = (CAP_V - fill_q) < WW_V;
        flags.almost_empty = fill_q <= ae_lvl;
        flags.almost_full  = fill_q >= af_lvl;
        wr_ok              = wr_req && !flags.full;
        rd_ok              = rd_req && !flags.empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_q + (wr_ok ? WW_V : '0) - (rd_ok ? RW_V : '0);
        end
    end
endmodule

// File: rtl/mixw_fifo.sv
module mixw_fifo
    import mixw_fifo_pkg::*;
#(
    parameter int unsigned WR_W = 4,
    parameter int unsigned RD_W = 1,
    localparam int unsigned CAP = span_bits(WR_W, RD_W),
    localparam int unsigned PW  = $clog2(CAP),
    localparam int unsigned CW  = $clog2(CAP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    input  logic [CW-1:0]   ae_level,
    input  logic [CW-1:0]   af_level,
    output logic            empty,
    output logic            full,
    output logic            almost_empty,
    output logic            almost_full
);
    flag_t         flg;
    logic          wr_ok;
    logic          rd_ok;
    logic          adv   [2];
    logic [PW-1:0] ptr_q [2];

    mixw_fifo_level #(.CAP(CAP), .WW(WR_W), .RW(RD_W), .CW(CW)) u_level (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_en),
        .rd_req (rd_en),
        .ae_lvl (ae_level),
        .af_lvl (af_level),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .flags  (flg)
    );

    assign adv[0] = wr_ok;
    assign adv[1] = rd_ok;

    // index 0 walks the write side, index 1 the read side
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        mixw_fifo_ptr #(.STEP(g == 0 ? WR_W : RD_W), .CAP(CAP), .PW(PW)) u_ptr (
            .clk (clk),
            .rst (rst),
            .adv (adv[g]),
            .ptr (ptr_q[g])
        );
    end

    mixw_fifo_store #(.CAP(CAP), .WW(WR_W), .RW(RD_W), .PW(PW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_ok),
        .wptr  (ptr_q[0]),
        .wdata (wr_data),
        .re    (rd_ok),
        .rptr  (ptr_q[1]),
        .rdata (rd_data)
    );

    assign empty        = flg.empty;
    assign full         = flg.full;
    assign almost_empty = flg.almost_empty;
    assign almost_full  = flg.almost_full;
endmodule

// File: rtl/mixw_fifo_chk.sv
module mixw_fifo_chk #(
    parameter int unsigned RD_W = 1,
    parameter int unsigned CW   = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            rd_en,
    input logic [RD_W-1:0] rd_data,
    input logic [CW-1:0]   ae_level,
    input logic [CW-1:0]   af_level,
    input logic            empty,
    input logic            full,
    input logic            almost_empty,
    input logic            almost_full
);
    // R4 R5
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst) !(empty && full));

    // R6
    full_stay_chk: assert property (@(posedge clk) disable iff (rst)
        full && !rd_en |=> full);

    // R7
    empty_stay_chk: assert property (@(posedge clk) disable iff (rst)
        empty && !wr_en |=> empty && $stable(rd_data));

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R8
    af_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(almost_full) && $stable(af_level) |-> $past(wr_en));

    // R9
    ae_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(almost_empty) && $stable(ae_level) |-> $past(rd_en));
endmodule

bind mixw_fifo mixw_fifo_chk #(.RD_W(RD_W), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .ae_level     (ae_level),
    .af_level     (af_level),
    .empty        (empty),
    .full         (full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
);

// File: tb/sim_mixw_fifo.sv
module sim_mixw_fifo;
    localparam int WR_W = 4;
    localparam int RD_W = 1;
    localparam int CAPB = 4096;
    localparam int CW   = 13;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [WR_W-1:0] wr_data = '0;
    logic            rd_en = 1'b0;
    logic [RD_W-1:0] rd_data;
    logic [CW-1:0]   ae_level = 13'd4;
    logic [CW-1:0]   af_level = 13'd12;
    logic            empty, full, almost_empty, almost_full;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    logic q[$];
    logic exp_rd = 1'b0;

    always #5 clk = ~clk;

    mixw_fifo #(.WR_W(WR_W), .RD_W(RD_W)) u0 (
        .clk, .rst, .wr_en, .wr_data, .rd_en, .rd_data,
        .ae_level, .af_level, .empty, .full, .almost_empty, .almost_full
    );

    task automatic check_val(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // compares {empty, full, almost_empty, almost_full, rd_data} with the model
    task automatic check_all(input string tag);
        int sz = q.size();
        logic [4:0] e, a;
        e = {sz < RD_W, (CAPB - sz) < WR_W, sz <= int'(ae_level), sz >= int'(af_level), exp_rd};
        a = {empty, full, almost_empty, almost_full, rd_data};
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (e,f,ae,af,rd) fill=%0d", tag, a, e, sz);
        end
    endtask

    // drive at a falling edge, model at the rising edge, check at the next falling edge
    task automatic step(input logic we, input logic [WR_W-1:0] wd, input logic re, input string tag);
        bit wacc, racc;
        wr_en = we; wr_data = wd; rd_en = re;
        @(posedge clk);
        wacc = we && ((CAPB - q.size()) >= WR_W);
        racc = re && (q.size() >= RD_W);
        if (racc) exp_rd = q.pop_front();
        if (wacc) for (int i = 0; i < WR_W; i++) q.push_back(wd[i]);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_all(tag);
    endtask

    task automatic t_reset;
        check_all("R1 reset state");
        check_val("R1 rd_data zero", int'(rd_data), 0);
    endtask

    task automatic t_order;
        step(1'b1, 4'b1011, 1'b0, "R2 write a");
        step(1'b1, 4'b0110, 1'b0, "R2 write b");
        for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b1, "R2 lsb first read");
        step(1'b0, '0, 1'b0, "R2 hold no read");
        check_val("R2 last bit is bit3 of b", int'(rd_data), 0);
    endtask

    task automatic t_simul;
        int n = 0;
        step(1'b1, 4'hA, 1'b0, "R10 prefill");
        step(1'b1, 4'h5, 1'b0, "R10 prefill");
        for (int i = 0; i < 6; i++) step(1'b1, 4'(i + 3), 1'b1, "R10 write and read");
        while (!empty && n < 100) begin
            step(1'b0, '0, 1'b1, "R10 drain");
            n++;
        end
        check_val("R10 bits left after concurrent traffic", n, 26);
    endtask

    task automatic t_full;
        int n = 0;
        for (int i = 0; i < 1024; i++) begin
            check_val("R5 not full before capacity", int'(full), 0);
            step(1'b1, 4'(i * 7 + 3), 1'b0, "R5 fill");
        end
        check_val("R5 full at 4096 bits", int'(full), 1);
        for (int i = 0; i < 5; i++) step(1'b1, 4'hF, 1'b0, "R6 write while full");
        while (!empty && n < 5000) begin
            step(1'b0, '0, 1'b1, "R3 R6 drain after wrap");
            n++;
        end
        check_val("R6 only 4096 bits came out", n, 4096);
    endtask

    task automatic t_empty_read;
        logic held = rd_data;
        for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, "R7 read while empty");
        check_val("R7 rd_data held", int'(rd_data), int'(held));
        step(1'b1, 4'b0010, 1'b0, "R7 write after empty reads");
        step(1'b0, '0, 1'b1, "R7 first bit");
        step(1'b0, '0, 1'b1, "R7 second bit");
        check_val("R7 new data bit1", int'(rd_data), 1);
        step(1'b0, '0, 1'b1, "R7 drain");
        step(1'b0, '0, 1'b1, "R7 drain");
        check_val("R4 empty after drain", int'(empty), 1);
    endtask

    task automatic t_thresh;
        ae_level = 13'd5; af_level = 13'd9;
        @(negedge clk);
        check_all("R8 R9 thresholds changed while idle");
        step(1'b1, 4'h3, 1'b0, "R9 fill 4 at or below ae");
        check_val("R9 ae at 4 bits", int'(almost_empty), 1);
        step(1'b1, 4'h6, 1'b0, "R8 fill 8 below af");
        check_val("R8 af clear at 8 bits", int'(almost_full), 0);
        check_val("R9 ae clear at 8 bits", int'(almost_empty), 0);
        step(1'b0, '0, 1'b1, "R9 read to 7");
        step(1'b0, '0, 1'b1, "R9 read to 6");
        step(1'b0, '0, 1'b1, "R9 read to 5");
        check_val("R9 ae set at threshold", int'(almost_empty), 1);
        for (int i = 0; i < 4; i++) step(1'b1, 4'(i), 1'b0, "R8 refill");
        check_val("R8 af set at or above threshold", int'(almost_full), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_simul();
        t_full();
        t_empty_read();
        t_thresh();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule